// File: doc/BRIEF.md
# Pulse-Width Serial Frame Receiver

This block listens to a single-wire control line from a car-audio head unit on which every bit is one high pulse (the line arrives already synchronized and inverted, so a bit begins with a rising edge). A short pulse means 0 and a long pulse means 1. Pulse length is measured in ticks of a programmable prescaler. Each measured bit is shifted MSB first into 4-bit nibbles. The frame ends when the line has stayed low for an idle interval.

When a frame closes, the block posts its nibbles, its nibble count and three verdict flags, and it raises a one-clock completion strobe. The verdict covers a checksum over the nibbles, the frame's shape and any pulse-width error. The consumer captures the outputs on the strobe. They stay unchanged until the next frame closes.

The bus source cannot be paused, so the result port has no ready signal and offers no back-pressure. Any consumer must accept one frame result per strobe. Successive strobes are always at least one idle interval apart.

Top module: `pwm_frame_rx`

## Requirements
- R1: After reset, frame_done, frame_ok, frame_bad and frame_err are 0, and frame_len and frame_nibbles are all zeros.
- R2: Pulse width is counted in ticks, and one tick is PRESCALE clocks. A high pulse of fewer than T1_MIN_TICKS ticks decodes as bit 0.
- R3: A high pulse of at least T1_MIN_TICKS ticks and at most T1_MAX_TICKS ticks decodes as bit 1.
- R4: A high pulse longer than T1_MAX_TICKS ticks marks the frame as erroneous. The report then has frame_err=1, frame_ok=0 and frame_len=0.
- R5: Bits are gathered MSB first into nibbles. Nibble k of a frame appears at frame_nibbles[4k+3:4k], so the first nibble received sits in the lowest four bits.
- R6: A frame closes after the line has been low for IDLE_TICKS ticks following its last bit. frame_done is then high for exactly one clock. Idle time with no bits received produces no frame_done.
- R7: frame_ok is 1 only when the last nibble equals the XOR of all earlier nibbles plus one, modulo 16, and the frame is neither malformed nor erroneous.
- R8: A frame is malformed (frame_bad=1, frame_ok=0) in any of three cases: its bit count is not a multiple of 4, it has fewer than 2 nibbles, or it has more than NIB_MAX nibbles. In the overflow case only the first NIB_MAX nibbles are kept, and frame_len is NIB_MAX.
- R9: All result outputs hold their values between frame_done strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Synchronized, inverted bus line; high while a pulse is active |
| frame_done | output | 1 | One-clock strobe when a frame result is posted |
| frame_ok | output | 1 | Checksum matched and frame well formed |
| frame_bad | output | 1 | Frame malformed (bit count, too few or too many nibbles) |
| frame_err | output | 1 | A pulse exceeded the maximum width |
| frame_len | output | LEN_W (5) | Number of nibbles stored |
| frame_nibbles | output | 4*NIB_MAX (64) | Stored nibbles, first received in the lowest bits |

## Verification
Assertions check the following on every cycle:
- a decoded bit is reported only just after a falling edge of the line;
- the idle and completion strobes last a single clock;
- the results stay still between strobes;
- the nibble counter never exceeds the buffer depth.

Only the bench's scenarios can show the value-dependent behaviour:
- the short/long/overlong pulse classification;
- MSB-first nibble placement;
- the checksum verdict on matching and mismatching frames;
- each malformed-frame case, including the overflow case;
- the absence of a strobe when the line idles without bits.

// File: rtl/pwmrx_pkg.sv
package pwmrx_pkg;
  typedef logic [3:0] nibble_t;

  // expected check nibble for a given running XOR
  function automatic nibble_t check_code(nibble_t acc);
    return acc + 4'd1;
  endfunction
endpackage

// File: rtl/pwmrx_tick.sv
module pwmrx_tick #(
  parameter int PRESCALE = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else if (div_q == LAST) begin
      div_q <= '0;
      tick  <= 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
      tick  <= 1'b0;
    end
  end

  generate
    if (PRESCALE > 1) begin : g_div
      // R2
      tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pwmrx_pulse_meas.sv
module pwmrx_pulse_meas #(
  parameter int CNT_W        = 16,
  parameter int T1_MIN_TICKS = 1200,
  parameter int T1_MAX_TICKS = 2500,
  parameter int IDLE_TICKS   = 4500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  output logic bit_stb,
  output logic bit_val,
  output logic bit_err,
  output logic gap_stb
);
  localparam logic [CNT_W-1:0] ONE_MIN  = CNT_W'(T1_MIN_TICKS);
  localparam logic [CNT_W-1:0] ONE_MAX  = CNT_W'(T1_MAX_TICKS);
  localparam logic [CNT_W-1:0] IDLE_END = CNT_W'(IDLE_TICKS - 1);

  logic             line_q;
  logic [CNT_W-1:0] width_q;
  logic [CNT_W-1:0] idle_q;
  logic             idle_seen_q;
  logic             rise, fall;

  assign rise = line & ~line_q;
  assign fall = ~line & line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q      <= 1'b0;
      width_q     <= '0;
      idle_q      <= '0;
      idle_seen_q <= 1'b0;
      bit_stb     <= 1'b0;
      bit_val     <= 1'b0;
      bit_err     <= 1'b0;
      gap_stb     <= 1'b0;
    end else begin
      line_q  <= line;
      bit_stb <= 1'b0;
      gap_stb <= 1'b0;
      // pulse width, saturating
      if (rise)
        width_q <= '0;
      else if (line_q && tick && (width_q != '1))
        width_q <= width_q + 1'b1;
      if (fall) begin
        bit_stb <= 1'b1;
        bit_val <= (width_q >= ONE_MIN);
        bit_err <= (width_q > ONE_MAX);
      end
      // idle time, one strobe per low stretch
      if (line_q) begin
        idle_q      <= '0;
        idle_seen_q <= 1'b0;
      end else if (tick && !idle_seen_q) begin
        if (idle_q == IDLE_END) begin
          gap_stb     <= 1'b1;
          idle_seen_q <= 1'b1;
        end
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  // R2
  bit_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> (!line_q && $past(line_q)));

  // R6
  gap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_stb |=> !gap_stb);
endmodule

// File: rtl/pwmrx_frame_asm.sv
module pwmrx_frame_asm
  import pwmrx_pkg::*;
#(
  parameter int NIB_MAX = 16,
  parameter int LEN_W   = $clog2(NIB_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_stb,
  input  logic                 bit_val,
  input  logic                 bit_err,
  input  logic                 gap_stb,
  output logic                 frame_done,
  output logic                 frame_ok,
  output logic                 frame_bad,
  output logic                 frame_err,
  output logic [LEN_W-1:0]     frame_len,
  output logic [4*NIB_MAX-1:0] frame_nibbles
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(NIB_MAX);

  nibble_t          buf_q [NIB_MAX];
  logic [4*NIB_MAX-1:0] buf_flat;
  logic [1:0]       phase_q;
  logic [2:0]       shift_q;
  logic [LEN_W-1:0] count_q;
  logic             ovf_q, perr_q, seen_q;
  nibble_t          xor_all_q, xor_prev_q, last_q;
  nibble_t          new_nib;
  logic             shape_bad;

  assign new_nib   = {shift_q, bit_val};
  assign shape_bad = (phase_q != 2'd0) || (count_q < LEN_W'(2)) || ovf_q;

  always_comb begin
    for (int i = 0; i < NIB_MAX; i++) buf_flat[4*i +: 4] = buf_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NIB_MAX; i++) buf_q[i] <= '0;
      phase_q       <= '0;
      shift_q       <= '0;
      count_q       <= '0;
      ovf_q         <= 1'b0;
      perr_q        <= 1'b0;
      seen_q        <= 1'b0;
      xor_all_q     <= '0;
      xor_prev_q    <= '0;
      last_q        <= '0;
      frame_done    <= 1'b0;
      frame_ok      <= 1'b0;
      frame_bad     <= 1'b0;
      frame_err     <= 1'b0;
      frame_len     <= '0;
      frame_nibbles <= '0;
    end else begin
      frame_done <= 1'b0;
      if (gap_stb && seen_q) begin
        frame_done    <= 1'b1;
        frame_err     <= perr_q;
        frame_bad     <= shape_bad;
        frame_ok      <= !shape_bad && !perr_q && (check_code(xor_prev_q) == last_q);
        frame_len     <= perr_q ? '0 : count_q;
        frame_nibbles <= perr_q ? '0 : buf_flat;
        for (int i = 0; i < NIB_MAX; i++) buf_q[i] <= '0;
        phase_q    <= '0;
        shift_q    <= '0;
        count_q    <= '0;
        ovf_q      <= 1'b0;
        perr_q     <= 1'b0;
        seen_q     <= 1'b0;
        xor_all_q  <= '0;
        xor_prev_q <= '0;
        last_q     <= '0;
      end else if (bit_stb) begin
        seen_q  <= 1'b1;
        phase_q <= phase_q + 1'b1;
        if (bit_err) perr_q <= 1'b1;
        if (phase_q == 2'd3) begin
          if (count_q == FULL) begin
            ovf_q <= 1'b1;
          end else begin
            for (int i = 0; i < NIB_MAX; i++)
              if (count_q == LEN_W'(i)) buf_q[i] <= new_nib;
            count_q    <= count_q + 1'b1;
            xor_prev_q <= xor_all_q;
            xor_all_q  <= xor_all_q ^ new_nib;
            last_q     <= new_nib;
          end
        end else begin
          shift_q <= {shift_q[1:0], bit_val};
        end
      end
    end
  end

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> ($stable(frame_ok) && $stable(frame_len) &&
                     $stable(frame_bad) && $stable(frame_nibbles)));
endmodule

// File: rtl/pwm_frame_rx.sv
module pwm_frame_rx #(
  parameter int PRESCALE     = 16,
  parameter int CNT_W        = 16,
  parameter int T1_MIN_TICKS = 1200,
  parameter int T1_MAX_TICKS = 2500,
  parameter int IDLE_TICKS   = 4500,
  parameter int NIB_MAX      = 16,
  parameter int LEN_W        = $clog2(NIB_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_line,
  output logic                 frame_done,
  output logic                 frame_ok,
  output logic                 frame_bad,
  output logic                 frame_err,
  output logic [LEN_W-1:0]     frame_len,
  output logic [4*NIB_MAX-1:0] frame_nibbles
);
  logic tick;
  logic bit_stb, bit_val, bit_err, gap_stb;

  pwmrx_tick #(.PRESCALE(PRESCALE)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pwmrx_pulse_meas #(
    .CNT_W(CNT_W), .T1_MIN_TICKS(T1_MIN_TICKS),
    .T1_MAX_TICKS(T1_MAX_TICKS), .IDLE_TICKS(IDLE_TICKS)
  ) meas_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(rx_line),
    .bit_stb(bit_stb), .bit_val(bit_val), .bit_err(bit_err), .gap_stb(gap_stb)
  );

  pwmrx_frame_asm #(.NIB_MAX(NIB_MAX), .LEN_W(LEN_W)) asm_i (
    .clk(clk), .rst_n(rst_n),
    .bit_stb(bit_stb), .bit_val(bit_val), .bit_err(bit_err), .gap_stb(gap_stb),
    .frame_done(frame_done), .frame_ok(frame_ok), .frame_bad(frame_bad),
    .frame_err(frame_err), .frame_len(frame_len), .frame_nibbles(frame_nibbles)
  );
endmodule

// File: tb/pwm_frame_rx_tb_top.sv
`timescale 1ns/1ps
module pwm_frame_rx_tb_top;
  localparam int NIB_MAX = 16;
  localparam int LEN_W   = 5;
  localparam int W_ZERO  = 6;   // clocks high for a 0 (3 ticks)
  localparam int W_ONE   = 18;  // 9 ticks
  localparam int W_LONG  = 40;  // 20 ticks
  localparam int CELL    = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b0;
  logic frame_done, frame_ok, frame_bad, frame_err;
  logic [LEN_W-1:0] frame_len;
  logic [4*NIB_MAX-1:0] frame_nibbles;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pwm_frame_rx #(
    .PRESCALE(2), .CNT_W(16), .T1_MIN_TICKS(6), .T1_MAX_TICKS(12),
    .IDLE_TICKS(22), .NIB_MAX(NIB_MAX), .LEN_W(LEN_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
    .frame_done(frame_done), .frame_ok(frame_ok), .frame_bad(frame_bad),
    .frame_err(frame_err), .frame_len(frame_len), .frame_nibbles(frame_nibbles)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input int w);
    @(negedge clk); rx_line = 1'b1;
    repeat (w) @(negedge clk);
    rx_line = 1'b0;
    repeat (CELL - w) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    pulse(b ? W_ONE : W_ZERO);
  endtask

  task automatic send_nib(input logic [3:0] n);
    for (int i = 3; i >= 0; i--) send_bit(n[i]);
  endtask

  task automatic wait_done(output logic seen);
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (frame_done) begin seen = 1'b1; break; end
    end
  endtask

  task automatic expect_frame(input string tag, input logic ok, input logic bad,
                              input logic err, input int len, input logic [63:0] nibs);
    logic seen;
    wait_done(seen);
    check({tag, " R6 done"}, 64'(seen), 64'd1);
    check({tag, " R7 ok"}, 64'(frame_ok), 64'(ok));
    check({tag, " R8 bad"}, 64'(frame_bad), 64'(bad));
    check({tag, " R4 err"}, 64'(frame_err), 64'(err));
    check({tag, " R5 len"}, 64'(frame_len), 64'(len));
    check({tag, " R5 nibbles"}, frame_nibbles, nibs);
    @(negedge clk);
    check({tag, " R6 one-cycle"}, 64'(frame_done), 64'd0);
  endtask

  task automatic t_reset();
    check("R1 done", 64'(frame_done), 64'd0);
    check("R1 ok", 64'(frame_ok), 64'd0);
    check("R1 bad/err", 64'({frame_bad, frame_err}), 64'd0);
    check("R1 len", 64'(frame_len), 64'd0);
    check("R1 nibbles", frame_nibbles, 64'd0);
  endtask

  task automatic t_idle_no_bits();
    logic seen;
    wait_done(seen);
    check("R6 idle without bits", 64'(seen), 64'd0);
  endtask

  // R2 R3 R5 R7: valid three-nibble frames
  task automatic t_ping();
    send_nib(4'h1); send_nib(4'h8); send_nib(4'hA);
    expect_frame("ping", 1, 0, 0, 3, 64'hA81);
  endtask

  task automatic t_pong();
    send_nib(4'h9); send_nib(4'h8); send_nib(4'h2);
    expect_frame("pong", 1, 0, 0, 3, 64'h289);
  endtask

  // R7: wrong checksum, then R9: held
  task automatic t_bad_sum_hold();
    send_nib(4'h1); send_nib(4'h8); send_nib(4'hB);
    expect_frame("badsum R7", 0, 0, 0, 3, 64'hB81);
    repeat (150) @(negedge clk);
    check("R9 hold len", 64'(frame_len), 64'd3);
    check("R9 hold nibbles", frame_nibbles, 64'hB81);
    check("R9 hold done", 64'(frame_done), 64'd0);
  endtask

  task automatic t_four_nib();
    send_nib(4'h3); send_nib(4'hC); send_nib(4'h5); send_nib(4'hB);
    expect_frame("four R7", 1, 0, 0, 4, 64'hB5C3);
  endtask

  // R8: partial nibble
  task automatic t_partial();
    send_nib(4'h1); send_nib(4'h8); send_bit(1'b1); send_bit(1'b0);
    expect_frame("partial R8", 0, 1, 0, 2, 64'h81);
  endtask

  // R8: too few nibbles
  task automatic t_short();
    send_nib(4'h5);
    expect_frame("single R8", 0, 1, 0, 1, 64'h5);
  endtask

  // R4: overlong pulse
  task automatic t_long();
    logic seen;
    send_nib(4'hF); pulse(W_LONG); send_nib(4'h2); send_nib(4'h3);
    wait_done(seen);
    check("R4 done", 64'(seen), 64'd1);
    check("R4 err", 64'(frame_err), 64'd1);
    check("R4 ok", 64'(frame_ok), 64'd0);
    check("R4 len", 64'(frame_len), 64'd0);
  endtask

  // R8: overflow beyond NIB_MAX
  task automatic t_overflow();
    logic [63:0] exp;
    for (int i = 0; i < NIB_MAX; i++) exp[4*i +: 4] = 4'(i);
    for (int i = 0; i < NIB_MAX + 1; i++) send_nib(4'(i));
    expect_frame("overflow R8", 0, 1, 0, NIB_MAX, exp);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_no_bits();
    t_ping();
    t_pong();
    t_bad_sum_hold();
    t_four_nib();
    t_partial();
    t_short();
    t_long();
    t_overflow();
    finish_run();
  end
endmodule